// File: doc/BRIEF.md
# Accumulator Microcontroller with Registered Buses

A small accumulator machine with an 8-bit data path and a 4-bit address space. Program and data share one 16-byte ROM whose contents are fixed by a parameter at elaboration time. Each instruction is a single byte: the upper nibble selects the operation and the lower nibble names a ROM location that holds the operand. Four operations exist: load the accumulator, add to it, copy it to the output register, and stop.

Every transfer between registers goes through one of two shared buses, one for addresses and one for data. Each bus is a multiplexer followed by a register, with no internal tristates. Each step of the fetch and execute sequence therefore takes one clock. The surrounding system sees only the output register and a flag that reports the machine has stopped. Asserting the asynchronous active-low reset restarts the machine from address 0.

Top module: `acc_mcu`

## Requirements
- R1: While `rst_n` is low, and at once when it falls, `out_port` reads 0x00 and `halted` reads 0. After release, execution begins at ROM address 0 with the accumulator at 0x00.
- R2: ROM byte i occupies bits [8i+7:8i] of parameter `ROM_IMAGE`. Within an instruction byte, bits [7:4] hold the opcode and bits [3:0] hold the operand's ROM address.
- R3: Opcode 0x8 (load) copies the ROM byte at the operand address into the accumulator. The instruction takes 8 clocks from the start of its fetch to the start of the next fetch.
- R4: Opcode 0x1 (add) replaces the accumulator with the accumulator plus the ROM byte at the operand address, modulo 256, with no carry kept. The instruction takes 10 clocks.
- R5: Opcode 0x9 (output) copies the accumulator into `out_port`. The new value appears after the 6th rising edge of that instruction, which also ends it. `out_port` changes at no other time except reset.
- R6: Opcode 0xF (halt) raises `halted` after the 5th rising edge of the instruction. From then on `halted` stays high and `out_port` holds its value until reset.
- R7: Any opcode other than 0x1, 0x8, 0x9 and 0xF, including 0x0 from an unused ROM location, behaves exactly like halt.
- R8: Instructions execute one per fetch, in increasing address order. A byte that follows a halt is never executed.
- R9: With the program 8C 1D 90 F0 at addresses 0 to 3, 0x55 at address C, 0x64 at address D and zeros elsewhere, `out_port` ends at 0xB9. `halted` first reads high after the 29th rising edge following reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_port | output | 8 | Output register, written by the output instruction |
| halted | output | 1 | High once a halt (or an undefined opcode) has executed |

## Verification
Reset is the only event that can arrive in the same cycle as a register load, such as the output-register write or the accumulator writeback at the end of an add. Runs are therefore cut short by a reset dropped mid-cycle at a cycle number drawn from a seeded random source. After that, `out_port` and `halted` must read zero without waiting for a clock edge. The program that follows must then replay exactly the cycle-by-cycle trace a bench model predicts from the opcode timings above, with no value left over from the interrupted instruction. Four machines with different ROM images run side by side, so both the wrap-around add and the undefined-opcode halt are exercised under every reset point.

// File: rtl/acc_mcu.sv
module acc_mcu #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [DW*(1<<AW)-1:0] ROM_IMAGE =
    128'h0000_6455_0000_0000_0000_0000_F090_1D8C
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] out_port,
  output logic          halted
);
  localparam int DEPTH = 1 << AW;
  localparam int OPW   = DW - AW;
  localparam logic [OPW-1:0] OP_ADD = OPW'(4'h1);
  localparam logic [OPW-1:0] OP_LD  = OPW'(4'h8);
  localparam logic [OPW-1:0] OP_OUT = OPW'(4'h9);
  localparam logic [2:0] ALU_ADD = 3'b001;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_F4, S_DEC, S_M2, S_M3, S_M4, S_A5, S_A6, S_O2, S_HLT
  } state_t;

  state_t state;
  logic [AW-1:0] pc, mar, abus;
  logic [DW-1:0] ir, acc, mdr, dbus, outr;
  logic [DW-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = ROM_IMAGE[i*DW +: DW];
  end

  wire [OPW-1:0] opc  = ir[DW-1:AW];
  wire [AW-1:0]  oper = ir[AW-1:0];

  function automatic logic [DW-1:0] alu(input logic [2:0] s,
                                        input logic [DW-1:0] a,
                                        input logic [DW-1:0] m);
    case (s)
      3'b000:  alu = a + DW'(1);
      3'b001:  alu = a + m;
      3'b010:  alu = a - m;
      3'b011:  alu = a - DW'(1);
      3'b100:  alu = ~a;
      3'b101:  alu = a & m;
      3'b110:  alu = a | m;
      default: alu = a ^ m;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_F1;
      pc    <= '0;
      mar   <= '0;
      abus  <= '0;
      ir    <= '0;
      acc   <= '0;
      mdr   <= '0;
      dbus  <= '0;
      outr  <= '0;
    end else begin
      case (state)
        S_F1: begin abus <= pc;        state <= S_F2; end
        S_F2: begin mar  <= abus;      state <= S_F3; end
        S_F3: begin dbus <= rom[mar];  state <= S_F4; end
        S_F4: begin
          ir    <= dbus;
          pc    <= pc + AW'(1);
          state <= S_DEC;
        end
        S_DEC: begin
          if (opc == OP_LD || opc == OP_ADD) begin
            abus  <= oper;
            state <= S_M2;
          end else if (opc == OP_OUT) begin
            dbus  <= acc;
            state <= S_O2;
          end else begin
            state <= S_HLT;
          end
        end
        S_M2: begin mar  <= abus;      state <= S_M3; end
        S_M3: begin dbus <= rom[mar];  state <= S_M4; end
        S_M4: begin
          if (opc == OP_LD) begin
            acc   <= dbus;
            state <= S_F1;
          end else begin
            mdr   <= dbus;
            state <= S_A5;
          end
        end
        S_A5: begin dbus <= alu(ALU_ADD, acc, mdr); state <= S_A6; end
        S_A6: begin acc  <= dbus;      state <= S_F1; end
        S_O2: begin outr <= dbus;      state <= S_F1; end
        default: state <= S_HLT;
      endcase
    end
  end

  assign out_port = outr;
  assign halted   = (state == S_HLT);

  p_load_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && opc == OP_LD) |=> (state == S_M2 && abus == $past(oper)));

  p_add_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_A6) |=> (acc == DW'($past(acc) + $past(mdr))));

  p_out_only_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_O2) |=> $stable(outr));

  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(acc) && $stable(pc)));

  p_undef_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && opc != OP_LD && opc != OP_ADD && opc != OP_OUT) |=> halted);

  p_pc_once_per_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_F4) |=> $stable(pc));
endmodule

// File: tb/acc_mcu_tb_top.sv
module acc_mcu_tb_top;
  localparam int NP   = 4;
  localparam int MAXC = 120;
  localparam logic [127:0] PROGS [NP] = '{
    128'h0000_6455_0000_0000_0000_0000_F090_1D8C,
    128'h20F0_0000_0000_0000_0035_9190_1F90_1F8E,
    128'h0000_0000_817F_0000_0000_0000_901B_908A,
    128'h0000_0000_0000_0000_0093_F790_1211_8090
  };

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] outs [NP];
  logic halts [NP];
  int total = 0, bad = 0;
  logic [7:0] exp_out [NP][MAXC+1];
  logic exp_halt [NP][MAXC+1];
  string exp_tag [NP][MAXC+1];
  int first_halt [NP];

  always #4 clk = ~clk;

  for (genvar k = 0; k < NP; k++) begin : g_dut
    acc_mcu #(.ROM_IMAGE(PROGS[k])) dut_i (
      .clk(clk), .rst_n(rst_n), .out_port(outs[k]), .halted(halts[k]));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic build(input int k);
    logic [7:0] acc, o, ins, nv;
    logic [3:0] op;
    int t, pc, len;
    bit done;
    string at;
    acc = 0; o = 0; t = 0; pc = 0; done = 0; at = "R1";
    for (int c = 0; c <= MAXC; c++) begin
      exp_out[k][c] = 0; exp_halt[k][c] = 0; exp_tag[k][c] = "R5";
    end
    while (!done && t < MAXC) begin
      ins = PROGS[k][pc*8 +: 8];
      op  = ins[7:4];
      pc  = (pc + 1) % 16;
      nv  = o;
      len = 5;
      case (op)
        4'h8: begin len = 8;  acc = PROGS[k][int'(ins[3:0])*8 +: 8]; at = "R3"; end
        4'h1: begin len = 10; acc = acc + PROGS[k][int'(ins[3:0])*8 +: 8]; at = "R4"; end
        4'h9: begin len = 6;  nv = acc; end
        default: len = 5;
      endcase
      if (op != 4'h8 && op != 4'h1 && op != 4'h9) begin
        for (int c = t + 1; c <= MAXC; c++) begin
          exp_out[k][c]  = o;
          exp_halt[k][c] = (c >= t + 5);
          if (c >= t + 5) exp_tag[k][c] = (op == 4'hF) ? "R6" : "R7";
        end
        done = 1;
      end else begin
        for (int c = t + 1; c <= t + len && c <= MAXC; c++) begin
          exp_out[k][c] = (c == t + len) ? nv : o;
          if (c == t + len && op == 4'h9) exp_tag[k][c] = at;
        end
        o = nv;
        t = t + len;
      end
    end
  endtask

  task automatic check_reset_state(input string what);
    for (int k = 0; k < NP; k++) begin
      chk(outs[k] === 8'h00, "R1", {what, " out_port"}, outs[k], 0);
      chk(halts[k] === 1'b0, "R1", {what, " halted"}, halts[k], 0);
    end
  endtask

  task automatic run_trace();
    @(negedge clk);
    check_reset_state("held reset");
    for (int k = 0; k < NP; k++) first_halt[k] = -1;
    rst_n = 1;
    for (int c = 1; c <= MAXC; c++) begin
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < NP; k++) begin
        chk(outs[k] === exp_out[k][c], exp_tag[k][c], "out_port trace",
            outs[k], exp_out[k][c]);
        chk(halts[k] === exp_halt[k][c], exp_halt[k][c] ? exp_tag[k][c] : "R6",
            "halted trace", halts[k], exp_halt[k][c]);
        if (halts[k] === 1'b1 && first_halt[k] < 0) first_halt[k] = c;
      end
    end
  endtask

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd1234));
    for (int k = 0; k < NP; k++) build(k);
    repeat (3) @(posedge clk);
    run_trace();
    chk(outs[0] === 8'hB9, "R9", "reference result", outs[0], 8'hB9);
    chk(first_halt[0] == 29, "R9", "reference halt edge", first_halt[0], 29);
    chk(outs[1] === 8'h30, "R2", "low-nibble operands, wrapped sum", outs[1], 8'h30);
    chk(outs[2] === 8'h00, "R4", "0x7F+0x81 wraps", outs[2], 8'h00);
    chk(first_halt[1] == 51, "R7", "opcode 0x3 halt edge", first_halt[1], 51);
    chk(first_halt[2] == 35, "R7", "opcode 0x0 halt edge", first_halt[2], 35);
    chk(outs[3] === 8'h21, "R8", "byte after halt not run", outs[3], 8'h21);
    chk(first_halt[3] == 45, "R8", "halt edge in order", first_halt[3], 45);
    for (int n = 0; n < 3; n++) begin
      r = 1 + int'($urandom % 60);
      repeat (r) @(posedge clk);
      @(negedge clk);
      rst_n = 0;
      #1;
      check_reset_state("async reset mid-run");
      repeat (1 + int'($urandom % 3)) @(posedge clk);
      run_trace();
      chk(outs[0] === 8'hB9, "R9", "reference result after reset", outs[0], 8'hB9);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule